// File: doc/BRIEF.md
# Power-to-Pulse-Rate Converter

This block turns a stream of signed real-power samples into pulse requests on two paths. Each accepted sample adds its magnitude to two accumulators. When an accumulator reaches its threshold, one single-cycle pulse request goes out and the threshold is subtracted, so the residue carries over. The slow path has the larger threshold and gives a rate proportional to average power, suited to driving a mechanical counter. The calibration path has a smaller threshold and gives a fast rate that follows instantaneous power, used when the meter is being calibrated.

A 2-bit rate select sets the slow-path full-scale rate as a binary fraction of the sample clock. A scale input, together with the rate select, picks how many times faster the calibration path runs. A leaky average of the sample magnitude provides a no-load gate: while that average is below a small fraction of full scale, samples are not accumulated, so no pulses appear. A reverse-power flag shows the sign of the sample that triggered the latest calibration pulse.

Top module: `pwr_pulse_conv`

## Requirements
- R1: A sample is accepted in a cycle where `clk_en_i` and `sample_vld_i` are both 1. The slow-path threshold is 2^(W-1+BASE_SHIFT-rate_sel_i), with `rate_sel_i` read as an unsigned number 0..3. A constant magnitude of 2^(W-1) on every accepted sample therefore gives one slow pulse per 2^(BASE_SHIFT-rate_sel_i) accepted samples.
- R2: With `cal_scale_i`=1, the calibration threshold is the slow threshold divided by 128, 64, 32 or 16 for `rate_sel_i` = 0, 1, 2 and 3.
- R3: With `cal_scale_i`=0, the calibration threshold is the slow threshold divided by 64, 32 or 16 for `rate_sel_i` = 0, 1 and 2, and by 2048 for `rate_sel_i` = 3 (high-frequency mode).
- R4: Each path adds the sample magnitude (the magnitude of -2^(W-1) is 2^(W-1)). When the sum reaches the threshold, the path keeps the sum minus the threshold and raises its pulse output for exactly the one cycle after the accepting clock edge. A path issues at most one pulse per accepted sample, and no pulse without an accepted sample.
- R5: A no-load average `avg` updates on every accepted sample as avg := avg + |s| - floor(avg / 2^AVG_SHIFT). It starts at 0. A sample is added to the accumulators only if the value of `avg` before that update is at least floor(2^(W-1+AVG_SHIFT) * NOLOAD_PPM / 10^6). Otherwise the sample has no effect on either path.
- R6: `rev_o` changes only on the edge that issues a calibration pulse. On that edge it takes 1 if the triggering sample was negative and 0 otherwise. It is not latched.
- R7: Full-scale DC power gives twice the slow-path pulse count of a full-scale sinusoid-like power waveform with half the mean, over the same number of samples.
- R8: While `rst_ni` is low, both accumulators, the no-load average and `rev_o` are cleared, and no pulses are issued.
- R9: On any clock edge where `rate_sel_i` or `cal_scale_i` differs from its value at the previous edge, both accumulators clear and that cycle's sample is not accumulated. The no-load average still updates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| clk_en_i | input | 1 | Master clock enable |
| sample_i | input | W | Signed real-power sample |
| sample_vld_i | input | 1 | Sample valid strobe |
| rate_sel_i | input | 2 | Slow-path rate select, bit 1 is the upper select |
| cal_scale_i | input | 1 | Calibration multiple table select |
| slow_pulse_o | output | 1 | Slow-path pulse request |
| cal_pulse_o | output | 1 | Calibration-path pulse request |
| rev_o | output | 1 | Reverse-power flag |

## Verification
The bench builds the block with BASE_SHIFT=14 instead of 21. This brings slow thresholds down to a few thousand full-scale samples, so slow pulses, residue carry and clearing on select changes all happen within a short run. In high-frequency mode, this setting makes the calibration threshold equal to one full-scale sample, which exercises the one-pulse-per-sample limit. AVG_SHIFT=4 and NOLOAD_PPM=20000 lift the no-load level to a magnitude of about 655. At that level, blocked and passing loads can be told apart with plain integer samples.

// File: rtl/pwr_pulse_pkg.sv
package pwr_pulse_pkg;
  localparam int NUM_PATHS    = 2;
  localparam int PATH_SLOW    = 0;
  localparam int PATH_CAL     = 1;
  localparam int HF_MULT_LOG2 = 11;

  // log2 of calibration-path multiple over the slow path
  function automatic int cal_mult_log2(input logic scf, input logic [1:0] sel);
    if (scf)              return 7 - int'(sel);
    else if (sel == 2'd3) return HF_MULT_LOG2;
    else                  return 6 - int'(sel);
  endfunction
endpackage

// File: rtl/pwr_mag.sv
module pwr_mag #(
  parameter int W = 16
) (
  input  logic signed [W-1:0] sample_i,
  output logic        [W-1:0] mag_o,
  output logic                neg_o
);
  assign neg_o = sample_i[W-1];
  assign mag_o = neg_o ? W'(-sample_i) : W'(sample_i);
endmodule

// File: rtl/pwr_noload.sv
module pwr_noload #(
  parameter int W          = 16,
  parameter int AVG_SHIFT  = 8,
  parameter int NOLOAD_PPM = 14
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         upd_i,
  input  logic [W-1:0] mag_i,
  output logic         load_ok_o
);
  localparam int AVG_W = W + AVG_SHIFT;
  localparam longint unsigned NL_FULL =
    ((64'd1 << (W - 1 + AVG_SHIFT)) * 64'(NOLOAD_PPM)) / 64'd1000000;
  localparam logic [AVG_W-1:0] NL_Q = AVG_W'(NL_FULL);

  logic [AVG_W-1:0] avg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    avg_q <= '0;
    else if (upd_i) avg_q <= avg_q + AVG_W'(mag_i) - (avg_q >> AVG_SHIFT);
  end

  assign load_ok_o = (avg_q >= NL_Q);
endmodule

// File: rtl/pwr_rate_dec.sv
module pwr_rate_dec
  import pwr_pulse_pkg::*;
#(
  parameter int W          = 16,
  parameter int BASE_SHIFT = 21,
  parameter int ACC_W      = W + BASE_SHIFT
) (
  input  logic                            cal_scale_i,
  input  logic [1:0]                      rate_sel_i,
  output logic [NUM_PATHS-1:0][ACC_W-1:0] thr_o
);
  int slow_sh;
  int cal_sh;

  always_comb begin
    slow_sh = W - 1 + BASE_SHIFT - int'(rate_sel_i);
    cal_sh  = slow_sh - cal_mult_log2(cal_scale_i, rate_sel_i);
    thr_o[PATH_SLOW] = ACC_W'(1) << slow_sh;
    thr_o[PATH_CAL]  = ACC_W'(1) << cal_sh;
  end
endmodule

// File: rtl/pwr_pulse_acc.sv
module pwr_pulse_acc #(
  parameter int W     = 16,
  parameter int ACC_W = 37
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             add_i,
  input  logic [W-1:0]     mag_i,
  input  logic [ACC_W-1:0] thr_i,
  output logic             fire_o,
  output logic             pulse_o
);
  localparam int SUM_W = ACC_W + 1;

  logic [ACC_W-1:0] acc_q;
  logic [SUM_W-1:0] sum;

  assign sum    = {1'b0, acc_q} + SUM_W'(mag_i);
  assign fire_o = add_i && !clr_i && (sum >= {1'b0, thr_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q   <= '0;
      pulse_o <= 1'b0;
    end else begin
      pulse_o <= fire_o;
      if (clr_i)       acc_q <= '0;
      else if (fire_o) acc_q <= ACC_W'(sum - {1'b0, thr_i});
      else if (add_i)  acc_q <= sum[ACC_W-1:0];
    end
  end
endmodule

// File: rtl/pwr_pulse_conv.sv
module pwr_pulse_conv
  import pwr_pulse_pkg::*;
#(
  parameter int W          = 16,
  parameter int BASE_SHIFT = 21,
  parameter int AVG_SHIFT  = 8,
  parameter int NOLOAD_PPM = 14
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clk_en_i,
  input  logic signed [W-1:0] sample_i,
  input  logic                sample_vld_i,
  input  logic [1:0]          rate_sel_i,
  input  logic                cal_scale_i,
  output logic                slow_pulse_o,
  output logic                cal_pulse_o,
  output logic                rev_o
);
  localparam int ACC_W = W + BASE_SHIFT;

  logic                            accept;
  logic                            load_ok;
  logic                            sel_chg;
  logic [1:0]                      sel_q;
  logic                            scf_q;
  logic [W-1:0]                    mag;
  logic                            neg;
  logic [NUM_PATHS-1:0][ACC_W-1:0] thr;
  logic [NUM_PATHS-1:0]            fire;
  logic [NUM_PATHS-1:0]            pulse;

  assign accept  = clk_en_i & sample_vld_i;
  assign sel_chg = (rate_sel_i != sel_q) || (cal_scale_i != scf_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= '0;
      scf_q <= 1'b0;
      rev_o <= 1'b0;
    end else begin
      sel_q <= rate_sel_i;
      scf_q <= cal_scale_i;
      if (fire[PATH_CAL]) rev_o <= neg;
    end
  end

  pwr_mag #(.W(W)) u_mag (
    .sample_i (sample_i),
    .mag_o    (mag),
    .neg_o    (neg)
  );

  pwr_noload #(.W(W), .AVG_SHIFT(AVG_SHIFT), .NOLOAD_PPM(NOLOAD_PPM)) u_noload (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .upd_i     (accept),
    .mag_i     (mag),
    .load_ok_o (load_ok)
  );

  pwr_rate_dec #(.W(W), .BASE_SHIFT(BASE_SHIFT), .ACC_W(ACC_W)) u_dec (
    .cal_scale_i (cal_scale_i),
    .rate_sel_i  (rate_sel_i),
    .thr_o       (thr)
  );

  for (genvar p = 0; p < NUM_PATHS; p++) begin : g_path
    pwr_pulse_acc #(.W(W), .ACC_W(ACC_W)) u_acc (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clr_i   (sel_chg),
      .add_i   (accept & load_ok),
      .mag_i   (mag),
      .thr_i   (thr[p]),
      .fire_o  (fire[p]),
      .pulse_o (pulse[p])
    );
  end

  assign slow_pulse_o = pulse[PATH_SLOW];
  assign cal_pulse_o  = pulse[PATH_CAL];
endmodule

// File: rtl/pwr_pulse_conv_chk.sv
module pwr_pulse_conv_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       clk_en_i,
  input logic       sample_vld_i,
  input logic [1:0] rate_sel_i,
  input logic       cal_scale_i,
  input logic       load_ok_i,
  input logic       slow_pulse_o,
  input logic       cal_pulse_o,
  input logic       rev_o
);
  logic armed_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else         armed_q <= 1'b1;
  end

  // R4
  slow_needs_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slow_pulse_o |-> $past(clk_en_i && sample_vld_i));

  // R4
  cal_needs_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cal_pulse_o |-> $past(clk_en_i && sample_vld_i));

  // R5
  noload_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slow_pulse_o || cal_pulse_o) |-> $past(load_ok_i));

  // R6
  rev_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cal_pulse_o |-> $stable(rev_o));

  // R9
  sel_change_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && ((rate_sel_i != $past(rate_sel_i)) || (cal_scale_i != $past(cal_scale_i))))
      |=> (!slow_pulse_o && !cal_pulse_o));
endmodule

bind pwr_pulse_conv pwr_pulse_conv_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .clk_en_i     (clk_en_i),
  .sample_vld_i (sample_vld_i),
  .rate_sel_i   (rate_sel_i),
  .cal_scale_i  (cal_scale_i),
  .load_ok_i    (load_ok),
  .slow_pulse_o (slow_pulse_o),
  .cal_pulse_o  (cal_pulse_o),
  .rev_o        (rev_o)
);

// File: tb/pwr_pulse_conv_tb.sv
`timescale 1ns/1ps
module pwr_pulse_conv_tb;
  localparam int W          = 16;
  localparam int BASE_SHIFT = 14;
  localparam int AVG_SHIFT  = 4;
  localparam int NOLOAD_PPM = 20000;
  localparam longint NLQ =
    ((64'd1 << (W - 1 + AVG_SHIFT)) * NOLOAD_PPM) / 1000000;

  logic                clk_i = 1'b0;
  logic                rst_ni = 1'b0;
  logic                clk_en_i = 1'b0;
  logic signed [W-1:0] sample_i = '0;
  logic                sample_vld_i = 1'b0;
  logic [1:0]          rate_sel_i = 2'd3;
  logic                cal_scale_i = 1'b1;
  logic                slow_pulse_o, cal_pulse_o, rev_o;

  pwr_pulse_conv #(.W(W), .BASE_SHIFT(BASE_SHIFT), .AVG_SHIFT(AVG_SHIFT),
                   .NOLOAD_PPM(NOLOAD_PPM)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .clk_en_i(clk_en_i), .sample_i(sample_i),
    .sample_vld_i(sample_vld_i), .rate_sel_i(rate_sel_i), .cal_scale_i(cal_scale_i),
    .slow_pulse_o(slow_pulse_o), .cal_pulse_o(cal_pulse_o), .rev_o(rev_o)
  );

  always #2.5 clk_i = ~clk_i;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  int cnt_slow, cnt_cal;

  longint m_acc_s, m_acc_c, m_avg;
  bit m_rev;
  logic [1:0] m_psel;
  bit m_pscf;

  function automatic int mult_log2(bit scf, int sel);
    case ({scf, sel[1:0]})
      3'b100: return 7;
      3'b101: return 6;
      3'b110: return 5;
      3'b111: return 4;
      3'b000: return 6;
      3'b001: return 5;
      3'b010: return 4;
      default: return 11;
    endcase
  endfunction

  function automatic longint slow_thr(int sel);
    return 64'd1 << (W - 1 + BASE_SHIFT - sel);
  endfunction

  task automatic check(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_clear();
    m_acc_s = 0; m_acc_c = 0; m_avg = 0; m_rev = 0; m_psel = 2'd0; m_pscf = 0;
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0; clk_en_i = 1'b0; sample_vld_i = 1'b0;
    model_clear();
    @(negedge clk_i);
    // R8: outputs idle in reset
    check("R8 slow in reset", slow_pulse_o, 0);
    check("R8 cal in reset", cal_pulse_o, 0);
    check("R8 rev in reset", rev_o, 0);
    rst_ni = 1'b1;
  endtask

  task automatic step(bit en, bit vld, logic signed [W-1:0] s);
    bit clr, ok, es, ec;
    longint mag, ts, tc;
    @(negedge clk_i);
    clk_en_i = en; sample_vld_i = vld; sample_i = s;
    @(posedge clk_i);
    #1;
    clr = (rate_sel_i != m_psel) || (cal_scale_i != m_pscf);
    m_psel = rate_sel_i; m_pscf = cal_scale_i;
    es = 0; ec = 0;
    ts = slow_thr(int'(rate_sel_i));
    tc = ts >> mult_log2(cal_scale_i, int'(rate_sel_i));
    if (clr) begin
      m_acc_s = 0; m_acc_c = 0;
    end
    if (en && vld) begin
      mag = (s < 0) ? -longint'(s) : longint'(s);
      ok = (m_avg >= NLQ);
      m_avg = m_avg + mag - (m_avg >> AVG_SHIFT);
      if (ok && !clr) begin
        m_acc_s += mag; m_acc_c += mag;
        if (m_acc_s >= ts) begin m_acc_s -= ts; es = 1; end
        if (m_acc_c >= tc) begin m_acc_c -= tc; ec = 1; m_rev = (s < 0); end
      end
    end
    check("R1/R4 slow pulse", slow_pulse_o, es);
    check("R2/R3 cal pulse", cal_pulse_o, ec);
    check("R6 rev flag", rev_o, m_rev);
    cnt_slow += slow_pulse_o;
    cnt_cal  += cal_pulse_o;
  endtask

  task automatic run_const(int n, logic signed [W-1:0] s);
    for (int i = 0; i < n; i++) step(1, 1, s);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int dc_cnt, tri_cnt;
    void'($urandom(32'd4242));
    model_clear();

    // R1, R2: full-scale negative DC, sel=3, scale=1
    rate_sel_i = 2'd3; cal_scale_i = 1'b1;
    do_reset();
    cnt_slow = 0; cnt_cal = 0;
    run_const(4097, -16'sd32768);
    check("R1 slow count at full scale", cnt_slow, 2);
    check("R2 cal count x16", cnt_cal, 32);
    check("R6 rev high on negative", rev_o, 1);

    // R3: high-frequency mode, one pulse per full-scale sample
    rate_sel_i = 2'd3; cal_scale_i = 1'b0;
    do_reset();
    cnt_slow = 0; cnt_cal = 0;
    run_const(257, -16'sd32768);
    check("R3 high-frequency cal count", cnt_cal, 256);

    // R6: positive power clears rev only at next cal pulse (sel0 scale1: 128 samples)
    rate_sel_i = 2'd0; cal_scale_i = 1'b1;
    run_const(10, 16'sd32767);
    check("R6 rev held without cal pulse", rev_o, 1);
    run_const(200, 16'sd32767);
    check("R6 rev low after positive cal pulse", rev_o, 0);

    // R9: select change discards residue
    rate_sel_i = 2'd0; cal_scale_i = 1'b1;
    do_reset();
    run_const(101, -16'sd32768);
    cal_scale_i = 1'b0;
    cnt_cal = 0;
    run_const(200, -16'sd32768);
    check("R9 residue cleared on select change", cnt_cal, 0);

    // R5: small load is blocked, larger load passes
    rate_sel_i = 2'd3; cal_scale_i = 1'b0;
    do_reset();
    cnt_slow = 0; cnt_cal = 0;
    run_const(3000, 16'sd300);
    check("R5 no pulses below no-load level", cnt_slow + cnt_cal, 0);
    run_const(500, 16'sd1000);
    check("R5 pulses above no-load level", cnt_cal > 0, 1);

    // R7: DC versus half-mean waveform
    rate_sel_i = 2'd3; cal_scale_i = 1'b1;
    do_reset();
    cnt_slow = 0;
    run_const(32768, 16'sd32640);
    dc_cnt = cnt_slow;
    do_reset();
    cnt_slow = 0;
    for (int i = 0; i < 32768; i++) begin
      int k;
      k = i % 256;
      step(1, 1, (k < 128) ? 16'(k * 256) : 16'((255 - k) * 256));
    end
    tri_cnt = cnt_slow;
    check("R7 DC rate is twice waveform rate",
          (dc_cnt - 2 * tri_cnt <= 2 && 2 * tri_cnt - dc_cnt <= 2), 1);

    // R4: random traffic, random modes, one mid-run reset
    for (int seg = 0; seg < 30; seg++) begin
      rate_sel_i = 2'($urandom % 4);
      cal_scale_i = 1'($urandom % 2);
      if (seg == 15) do_reset();
      for (int i = 0; i < 1000; i++) begin
        int r;
        logic signed [W-1:0] s;
        r = $urandom % 10;
        if (r == 0)      s = 16'($urandom % 401) - 16'sd200;
        else if (r == 9) s = ($urandom % 2) ? -16'sd32768 : 16'sd32767;
        else             s = 16'($urandom);
        step(($urandom % 8) != 0, ($urandom % 4) != 0, s);
      end
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule